// File: doc/BRIEF.md
# Serialized Local-Alignment Processor Array

This block scores a database character stream against a fixed query string with a local-alignment recurrence. The computation is a linear array of virtual cells, one per query character. Virtual cell p keeps the best score M[p] of an alignment that ends at query position p and at the current database character. The new value is the largest of four terms: zero, its own previous score less a gap penalty, the score the left neighbour produced for the same database character less a gap penalty, and the left neighbour's score for the previous database character plus a match bonus or less a mismatch penalty. For every database character accepted, the block returns the score of the last virtual cell.

To save area, `S` consecutive virtual cells share one physical cell. The shared cell visits its `S` slots in turn, one slot per cycle, so an array of `X` virtual cells needs ceil(X/S) physical cells and accepts one database character every `S` cycles. State that stays inside a virtual cell (its own previous score and its diagonal operand) is held in depth-`S` rotating shift lines. Values that cross from one virtual cell to the next go through a register with a one-cycle feedback path. That register loads the external input on one cycle in every `S` and keeps circulating the locally computed value on the other cycles. Physical cells pass data in one direction only, each through a register.

Top module: `sa_serial_array`

## Requirements
- R1: For each accepted database character j, the reported score equals M[X][j], where M[0][j]=0, M[p][0]=0 and M[p][j]=max(0, M[p][j-1]-8, M[p-1][j]-8, M[p-1][j-1]+15 if query character p equals the database character, otherwise M[p-1][j-1]-12). Query character p (p=1..X) is taken from `query_i[(p-1)*CW +: CW]`.
- R2: The array has ceil(X/S) physical cells. When X is not a multiple of S, the unused slots of the last physical cell pass their incoming score on unchanged, so R1 still holds.
- R3: While `en_i` is high, `db_ready_o` is high on exactly one cycle in every S cycles. A character is accepted only on a clock edge where `db_valid_i` and `db_ready_o` are both high.
- R4: A character accepted at clock edge n gives a one-cycle `score_valid_o` pulse in the cycle that follows edge n + ceil(X/S)*S.
- R5: A ready cycle with `db_valid_i` low produces no score pulse and leaves all scoring state unchanged. Later scores are the same as if that cycle had not occurred.
- R6: While `en_i` is low, no state changes, `db_ready_o` is low and `score_valid_o` is low. After `en_i` returns high, the scores are unaffected.
- R7: After `rst_ni` is released, all virtual-cell scores are zero, the slot counters are at slot 0, `score_valid_o` is low, `score_o` is zero and `db_ready_o` is low when S>1.
- R8: The slot counter in each physical cell wraps modulo S. The database register in each cell changes only on the load cycle and holds its value through its feedback path on the other cycles.
- R9: The score sequence does not depend on S. The configuration with S=3 reports the same scores as the unpartitioned configuration with S=1 for the same accepted characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Clock enable for all state |
| query_i | input | X*CW | Query characters, virtual cell p at bits (p-1)*CW |
| db_valid_i | input | 1 | Database character valid |
| db_char_i | input | CW | Database character |
| db_ready_o | output | 1 | Array takes a character on this edge |
| score_o | output | SW | Score of the last virtual cell |
| score_valid_o | output | 1 | One-cycle pulse, score_o is new |

## Verification
The recurrence is exercised with a database stream identical to the query, which drives the diagonal match chain to its maximum. A stream with no matching character must give all zeros. A mixed stream with shifted partial matches exercises the gap terms and the zero floor. With X=7 and S=3 the last physical cell has two idle slots, so every score also checks the pass-through. A skipped ready slot and an enable drop in the middle of a stream must leave the scores equal to those of the uninterrupted stream. Each stream also runs through an S=1 instance, and its scores are compared one for one with the serialized instance.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int GAP_PEN      = 8;
  localparam int MATCH_BONUS  = 15;
  localparam int MISMATCH_PEN = 12;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sa_phase_ctr.sv
module sa_phase_ctr #(
  parameter int S    = 3,
  parameter int CNTW = sa_pkg::cnt_width(S)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  output logic [CNTW-1:0] phase_o,
  output logic            last_o
);
  localparam logic [CNTW-1:0] LAST = CNTW'(S - 1);

  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (en_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign phase_o = cnt_q;
  assign last_o  = (cnt_q == LAST);

  assert_phase_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_phase_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && last_o) |=> (cnt_q == '0));
  assert_phase_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/sa_shift_line.sv
module sa_shift_line #(
  parameter int DEPTH = 3,
  parameter int W     = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] head_o
);
  logic [W-1:0] line_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] nxt;
    if (i == DEPTH - 1) begin : g_tail
      assign nxt = din_i;
    end else begin : g_mid
      assign nxt = line_q[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   line_q[i] <= '0;
      else if (en_i) line_q[i] <= nxt;
    end
  end

  assign head_o = line_q[0];

  assert_line_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(head_o));
endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
  parameter int CW = 8,
  parameter int SW = 16
) (
  input  logic                 active_i,
  input  logic [CW-1:0]        q_i,
  input  logic [CW-1:0]        db_i,
  input  logic signed [SW-1:0] left_i,
  input  logic signed [SW-1:0] up_i,
  input  logic signed [SW-1:0] diag_i,
  output logic signed [SW-1:0] score_o
);
  localparam logic signed [SW-1:0] GAP = SW'(sa_pkg::GAP_PEN);
  localparam logic signed [SW-1:0] MAT = SW'(sa_pkg::MATCH_BONUS);
  localparam logic signed [SW-1:0] MIS = SW'(sa_pkg::MISMATCH_PEN);

  logic signed [SW-1:0] t_up, t_left, t_diag, best;

  always_comb begin
    t_up   = up_i - GAP;
    t_left = left_i - GAP;
    t_diag = (q_i == db_i) ? diag_i + MAT : diag_i - MIS;
    best   = '0;
    if (t_up   > best) best = t_up;
    if (t_left > best) best = t_left;
    if (t_diag > best) best = t_diag;
    // idle slot forwards the left score untouched
    score_o = active_i ? best : left_i;
  end
endmodule

// File: rtl/sa_phys_cell.sv
module sa_phys_cell #(
  parameter int CW   = 8,
  parameter int SW   = 16,
  parameter int S    = 3,
  parameter int X    = 7,
  parameter int BASE = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [S*CW-1:0]      query_i,
  input  logic signed [SW-1:0] in_score_i,
  input  logic [CW-1:0]        in_db_i,
  input  logic                 in_vld_i,
  output logic signed [SW-1:0] out_score_o,
  output logic [CW-1:0]        out_db_o,
  output logic                 out_vld_o,
  output logic                 load_o
);
  localparam int CNTW  = sa_pkg::cnt_width(S);
  localparam int SLOTS = 1 << CNTW;

  logic [CNTW-1:0]      phase;
  logic                 last;
  logic signed [SW-1:0] left_q;
  logic [CW-1:0]        db_q;
  logic                 vld_q;
  logic signed [SW-1:0] res, up_head, diag_head;
  logic [SW-1:0]        up_din, diag_din, up_raw, diag_raw;
  logic [CW-1:0]        q_slot [SLOTS];
  logic [SLOTS-1:0]     act;

  sa_phase_ctr #(.S(S)) u_ctr (
    .clk_i, .rst_ni, .en_i, .phase_o(phase), .last_o(last)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < S && BASE + s < X) begin : g_used
      assign q_slot[s] = query_i[s*CW +: CW];
      assign act[s]    = 1'b1;
    end else begin : g_idle
      assign q_slot[s] = '0;
      assign act[s]    = 1'b0;
    end
  end

  sa_pe #(.CW(CW), .SW(SW)) u_pe (
    .active_i(act[phase]), .q_i(q_slot[phase]), .db_i(db_q),
    .left_i(left_q), .up_i(up_head), .diag_i(diag_head), .score_o(res)
  );

  // bubbles rotate the lines without changing them
  assign up_din   = vld_q ? res    : up_head;
  assign diag_din = vld_q ? left_q : diag_head;

  sa_shift_line #(.DEPTH(S), .W(SW)) u_up_line (
    .clk_i, .rst_ni, .en_i, .din_i(up_din), .head_o(up_raw)
  );
  sa_shift_line #(.DEPTH(S), .W(SW)) u_diag_line (
    .clk_i, .rst_ni, .en_i, .din_i(diag_din), .head_o(diag_raw)
  );
  assign up_head   = signed'(up_raw);
  assign diag_head = signed'(diag_raw);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      db_q   <= '0;
      vld_q  <= 1'b0;
    end else if (en_i) begin
      if (last) begin
        left_q <= in_score_i;
        db_q   <= in_db_i;
        vld_q  <= in_vld_i;
      end else begin
        left_q <= res;   // circulate to the next slot
      end
    end
  end

  assign out_score_o = res;
  assign out_db_o    = db_q;
  assign out_vld_o   = vld_q;
  assign load_o      = last;

  assert_db_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && last) |=> $stable(db_q));
  assert_vld_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && last) |=> $stable(vld_q));
endmodule

// File: rtl/sa_serial_array.sv
module sa_serial_array #(
  parameter int CW = 8,
  parameter int SW = 16,
  parameter int X  = 7,
  parameter int S  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [X*CW-1:0]      query_i,
  input  logic                 db_valid_i,
  input  logic [CW-1:0]        db_char_i,
  output logic                 db_ready_o,
  output logic [SW-1:0]        score_o,
  output logic                 score_valid_o
);
  localparam int NP = (X + S - 1) / S;
  localparam int QW = NP * S * CW;

  logic [QW-1:0]        q_pad;
  logic signed [SW-1:0] sc  [NP+1];
  logic [CW-1:0]        dbc [NP+1];
  logic [NP:0]          vc;
  logic [NP-1:0]        ld;
  logic signed [SW-1:0] score_q;
  logic                 valid_q;

  assign q_pad  = QW'(query_i);
  assign sc[0]  = '0;
  assign dbc[0] = db_char_i;
  assign vc[0]  = db_valid_i;

  for (genvar k = 0; k < NP; k++) begin : g_cell
    sa_phys_cell #(.CW(CW), .SW(SW), .S(S), .X(X), .BASE(k*S)) u_cell (
      .clk_i, .rst_ni, .en_i,
      .query_i(q_pad[k*S*CW +: S*CW]),
      .in_score_i(sc[k]), .in_db_i(dbc[k]), .in_vld_i(vc[k]),
      .out_score_o(sc[k+1]), .out_db_o(dbc[k+1]), .out_vld_o(vc[k+1]),
      .load_o(ld[k])
    );
  end

  assign db_ready_o = en_i && ld[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      score_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= en_i && ld[NP-1] && vc[NP];
      if (en_i && ld[NP-1] && vc[NP]) score_q <= sc[NP];
    end
  end

  assign score_o       = score_q;
  assign score_valid_o = valid_q;

  assert_idle_no_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !score_valid_o);
  assert_lockstep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld == '0) || (ld == '1));
  if (S > 1) begin : g_chk
    assert_ready_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      db_ready_o |=> !db_ready_o);
    assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      score_valid_o |=> !score_valid_o);
  end
endmodule

// File: tb/sa_serial_array_tb.sv
module sa_serial_array_tb;
  localparam int CW  = 8;
  localparam int SW  = 16;
  localparam int X   = 7;
  localparam int S   = 3;
  localparam int NP  = (X + S - 1) / S;
  localparam int LAT = NP * S;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [X*CW-1:0] query = '0;
  logic db_valid = 1'b0;
  logic [CW-1:0] db_char = '0;
  logic d_ready, d_valid, f_ready, f_valid;
  logic [SW-1:0] d_score, f_score;

  int checks = 0;
  int errors = 0;
  int dq[$];
  int fq[$];
  int expq[$];
  logic [CW-1:0] seq[16];

  always #5 clk = ~clk;

  sa_serial_array #(.CW(CW), .SW(SW), .X(X), .S(S)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .query_i(query),
    .db_valid_i(db_valid), .db_char_i(db_char), .db_ready_o(d_ready),
    .score_o(d_score), .score_valid_o(d_valid)
  );

  // unpartitioned array takes exactly the characters the serialized one takes
  sa_serial_array #(.CW(CW), .SW(SW), .X(X), .S(1)) u_flat (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .query_i(query),
    .db_valid_i(db_valid && d_ready), .db_char_i(db_char), .db_ready_o(f_ready),
    .score_o(f_score), .score_valid_o(f_valid)
  );

  always @(negedge clk) begin
    if (rst_n && d_valid) dq.push_back(int'(d_score));
    if (rst_n && f_valid) fq.push_back(int'(f_score));
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void ref_scores(input int n);
    int prev[X+1];
    int cur[X+1];
    int m;
    expq.delete();
    for (int p = 0; p <= X; p++) prev[p] = 0;
    for (int j = 0; j < n; j++) begin
      cur[0] = 0;
      for (int p = 1; p <= X; p++) begin
        m = 0;
        if (prev[p] - 8 > m) m = prev[p] - 8;
        if (cur[p-1] - 8 > m) m = cur[p-1] - 8;
        if (query[(p-1)*CW +: CW] == seq[j]) begin
          if (prev[p-1] + 15 > m) m = prev[p-1] + 15;
        end else begin
          if (prev[p-1] - 12 > m) m = prev[p-1] - 12;
        end
        cur[p] = m;
      end
      expq.push_back(cur[X]);
      for (int p = 0; p <= X; p++) prev[p] = cur[p];
    end
  endfunction

  task automatic set_query(input string s);
    for (int p = 0; p < X; p++) query[p*CW +: CW] = CW'(s[p]);
  endtask

  task automatic set_seq(input string s);
    for (int i = 0; i < s.len(); i++) seq[i] = CW'(s[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    db_valid = 1'b0;
    en = 1'b1;
    @(negedge clk);
    dq.delete();
    fq.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // stream n characters; optionally skip one ready slot or drop enable
  task automatic stream(input int n, input int bubble_at, input int stall_at);
    for (int i = 0; i < n; i++) begin
      if (i == stall_at) begin
        en = 1'b0;
        for (int c = 0; c < 5; c++) begin
          @(negedge clk);
          check(!d_ready, "R6 ready while disabled", int'(d_ready), 0);
          check(!d_valid, "R6 pulse while disabled", int'(d_valid), 0);
        end
        en = 1'b1;
      end
      while (!d_ready) @(negedge clk);
      if (i == bubble_at) begin
        @(negedge clk);
        while (!d_ready) @(negedge clk);
      end
      db_valid = 1'b1;
      db_char = seq[i];
      @(negedge clk);
      db_valid = 1'b0;
    end
    repeat (LAT + 10) @(negedge clk);
  endtask

  task automatic compare(input int n, input string tag);
    ref_scores(n);
    check(dq.size() == n, {tag, " serialized score count"}, dq.size(), n);
    check(fq.size() == n, {tag, " R9 flat score count"}, fq.size(), n);
    for (int i = 0; i < n; i++) begin
      if (i < dq.size()) check(dq[i] == expq[i], {tag, " score"}, dq[i], expq[i]);
      if (i < dq.size() && i < fq.size())
        check(dq[i] == fq[i], "R9 serialized vs flat", dq[i], fq[i]);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(d_valid == 1'b0, "R7 valid after reset", int'(d_valid), 0);
    check(d_score == '0, "R7 score after reset", int'(d_score), 0);
    check(d_ready == 1'b0, "R7 ready after reset", int'(d_ready), 0);
  endtask

  task automatic t_ready_period();
    int cnt = 0;
    do_reset();
    for (int c = 0; c < 30; c++) begin
      if (d_ready) cnt++;
      @(negedge clk);
    end
    check(cnt == 30 / S, "R3 R8 ready once per S cycles", cnt, 30 / S);
  endtask

  task automatic t_latency();
    int lat = 0;
    do_reset();
    set_query("ABCDEFG");
    while (!d_ready) @(negedge clk);
    db_valid = 1'b1;
    db_char = "G";
    @(negedge clk);
    db_valid = 1'b0;
    while (!d_valid && lat < 40) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    check(lat == LAT, "R4 latency", lat, LAT);
    @(negedge clk);
    check(!d_valid, "R4 single-cycle pulse", int'(d_valid), 0);
  endtask

  task automatic t_all_match();
    do_reset();
    set_query("ABCDEFG");
    set_seq("ABCDEFGAB");
    stream(9, -1, -1);
    compare(9, "R1 R2 all-match");
  endtask

  task automatic t_no_match();
    do_reset();
    set_query("ABCDEFG");
    set_seq("ZZZZZ");
    stream(5, -1, -1);
    compare(5, "R1 no-match");
  endtask

  task automatic t_mixed();
    do_reset();
    set_query("GATTACA");
    set_seq("TGATCACATTAG");
    stream(12, -1, -1);
    compare(12, "R1 R2 mixed");
  endtask

  task automatic t_bubble();
    do_reset();
    set_query("GATTACA");
    set_seq("GATTTACA");
    stream(8, 3, -1);
    compare(8, "R5 bubble");
  endtask

  task automatic t_stall();
    do_reset();
    set_query("ABCDEFG");
    set_seq("XABCDEFG");
    stream(8, -1, 4);
    compare(8, "R6 enable drop");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ready_period();
    t_latency();
    t_all_match();
    t_no_match();
    t_mixed();
    t_bubble();
    t_stall();
    finish_run();
  end
endmodule